// File: doc/BRIEF.md
# Two-Configuration Stage Swap Controller

This block runs a two-stage byte computation on one shared datapath slot, where only one of the two stages is resident at a time. After a start request it loads configuration 1, in which the producing stage takes bytes from an upstream valid/ready stream. It transforms each byte and writes it into an intermediate FIFO buffer. A fixed reconfiguration stall follows, during which nothing moves. Configuration 2 then holds the consuming stage. That stage drains the buffer in arrival order, applies its own transform and presents the bytes on a downstream valid/ready stream that may apply back-pressure. A second stall swaps the slot back.

The producing phase lasts a fixed number of clocks, equal to a multiple of the stall length. The buffer is sized to absorb one byte per clock over that phase. If the buffer fills first, input is refused so that it cannot overflow. Data flows only from the producing stage to the consuming stage, never back. When start is still high at the end of the second stall, a new pass begins at once. Otherwise the block returns to idle. The stages are modelled as a modular add of a constant (producer) and an XOR with a constant (consumer).

Top module: `stage_swap_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, `busy` is 0, `cfg` is 0, `in_ready` is 0 and `out_valid` is 0.
- R2: A start seen while idle causes a fixed sequence. First comes configuration 1 (`cfg`=1) for exactly RUN_MULT*RECONF_CYCLES clocks, then a stall. Next is configuration 2 (`cfg`=2), then a second stall. `cfg`=0 with `busy`=1 marks a stall.
- R3: During one producing phase at most BUF_DEPTH bytes are accepted. Once BUF_DEPTH bytes are stored, `in_ready` stays 0 for the rest of the phase. With `in_valid` held high the phase accepts min(run length, BUF_DEPTH) bytes.
- R4: Each stall lasts exactly RECONF_CYCLES clocks, with `in_ready` and `out_valid` both 0.
- R5: Each accepted byte x appears on the output exactly once, as ((x + A_ADD) mod 2^DATA_W) XOR B_MASK, in acceptance order. Every byte is delivered before the second stall begins.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value in the next cycle.
- R7: Configuration 2 ends after the buffer is empty and the last byte has been taken. At the end of the second stall the block enters configuration 1 again if `start` is 1, and goes idle otherwise.
- R8: Bytes offered outside configuration 1 are not taken: `in_ready` is 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a pass; sampled when idle and at the end of the second stall |
| in_data | input | DATA_W | Upstream byte |
| in_valid | input | 1 | Upstream byte present |
| in_ready | output | 1 | Byte taken this cycle when also valid |
| out_data | output | DATA_W | Processed byte |
| out_valid | output | 1 | Processed byte present |
| out_ready | input | 1 | Downstream takes the byte |
| cfg | output | 2 | Loaded configuration: 0 none, 1 producer, 2 consumer |
| busy | output | 1 | A pass is in progress |

## Verification
A wrong phase timer shows as a configuration-1 or stall window of the wrong length on `cfg`. This is visible when the window closes, within one pass. A wrong buffer pointer or occupancy shows as reordered, duplicated, missing or corrupted output bytes during the consumer phase of the same pass. It may also show as a wrong count of accepted input bytes at saturation. A broken output holding register shows in the first back-pressured cycle as a byte that changes or a valid that drops.

// File: rtl/stage_swap_pkg.sv
package stage_swap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN_A,
    ST_RECONF_1,
    ST_RUN_B,
    ST_RECONF_2
  } swap_state_e;

  localparam logic [1:0] CFG_NONE = 2'd0;
  localparam logic [1:0] CFG_PROD = 2'd1;
  localparam logic [1:0] CFG_CONS = 2'd2;
endpackage

// File: rtl/swap_xform.sv
module swap_xform #(
  parameter int W = 8,
  parameter int OP = 0,
  parameter logic [W-1:0] K = '0
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (OP == 0) begin : g_add
      assign q = d + K;
    end else begin : g_xor
      assign q = d ^ K;
    end
  endgenerate
endmodule

// File: rtl/swap_fifo.sv
module swap_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/swap_fsm.sv
module swap_fsm
  import stage_swap_pkg::*;
#(
  parameter int RECONF_CYCLES = 10,
  parameter int RUN_MULT = 100,
  localparam int RUN_LEN = RUN_MULT * RECONF_CYCLES,
  localparam int TMAX = (RUN_LEN > RECONF_CYCLES) ? RUN_LEN : RECONF_CYCLES,
  localparam int TW = $clog2(TMAX + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        drained,
  output swap_state_e state
);
  logic [TW-1:0] tmr;
  logic          run_end;
  logic          stall_end;

  assign run_end   = (tmr == TW'(RUN_LEN - 1));
  assign stall_end = (tmr == TW'(RECONF_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tmr <= '0;
          if (start) state <= ST_RUN_A;
        end
        ST_RUN_A: begin
          if (run_end) begin
            state <= ST_RECONF_1;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_RECONF_1: begin
          if (stall_end) begin
            state <= ST_RUN_B;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        ST_RUN_B: begin
          tmr <= '0;
          if (drained) state <= ST_RECONF_2;
        end
        ST_RECONF_2: begin
          if (stall_end) begin
            state <= start ? ST_RUN_A : ST_IDLE;
            tmr   <= '0;
          end else tmr <= tmr + 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          tmr   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/stage_swap_ctrl.sv
module stage_swap_ctrl
  import stage_swap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RECONF_CYCLES = 10,
  parameter int RUN_MULT = 100,
  parameter int BUF_DEPTH = 1024,
  parameter logic [DATA_W-1:0] A_ADD = 'h35,
  parameter logic [DATA_W-1:0] B_MASK = 'hA6,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        cfg,
  output logic              busy
);
  swap_state_e       state;
  logic [CW-1:0]     occ;
  logic              wr_en;
  logic              rd_en;
  logic              slot_free;
  logic              drained;
  logic [DATA_W-1:0] a_q;
  logic [DATA_W-1:0] buf_q;

  assign in_ready  = (state == ST_RUN_A) && (occ < CW'(BUF_DEPTH));
  assign wr_en     = in_valid && in_ready;
  assign slot_free = !out_valid || out_ready;
  assign rd_en     = (state == ST_RUN_B) && (occ != '0) && slot_free;
  assign drained   = (occ == '0) && slot_free;

  swap_fsm #(
    .RECONF_CYCLES(RECONF_CYCLES),
    .RUN_MULT(RUN_MULT)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .drained(drained), .state(state)
  );

  swap_xform #(.W(DATA_W), .OP(0), .K(A_ADD)) u_stage_a (.d(in_data), .q(a_q));

  swap_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(a_q),
    .rd_en(rd_en), .rd_data(buf_q), .occ(occ)
  );

  swap_xform #(.W(DATA_W), .OP(1), .K(B_MASK)) u_stage_b (.d(buf_q), .q(out_data));

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (rd_en) out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_comb begin
    busy = (state != ST_IDLE);
    case (state)
      ST_RUN_A: cfg = CFG_PROD;
      ST_RUN_B: cfg = CFG_CONS;
      default:  cfg = CFG_NONE;
    endcase
  end
endmodule

// File: rtl/stage_swap_ctrl_chk.sv
module stage_swap_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int BUF_DEPTH = 1024,
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        cfg,
  input logic              busy,
  input logic [CW-1:0]     occ
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cfg == 2'd0 && !in_ready && !out_valid));

  p_prod_to_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg == 2'd1) |=> (cfg == 2'd1 || (cfg == 2'd0 && busy)));

  p_cons_to_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg == 2'd2) |=> (cfg == 2'd2 || (cfg == 2'd0 && busy)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(BUF_DEPTH));

  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg == 2'd0) |-> (!in_ready && !out_valid));

  p_hold_out_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_ready_prod_only_r8: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (cfg == 2'd1));
endmodule

bind stage_swap_ctrl stage_swap_ctrl_chk #(
  .DATA_W(DATA_W),
  .BUF_DEPTH(BUF_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .cfg(cfg), .busy(busy),
  .occ(occ)
);

// File: tb/stage_swap_ctrl_tb.sv
`timescale 1ns/1ps
module stage_swap_ctrl_tb;
  localparam int W = 8;
  localparam int RC = 3;
  localparam int RM = 4;
  localparam int RUNL = RC * RM;
  localparam int DEPTH = 8;
  localparam logic [W-1:0] KADD = 8'h35;
  localparam logic [W-1:0] KMSK = 8'hA6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] out_data;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [1:0] cfg;
  logic busy;

  always #5 clk = ~clk;

  stage_swap_ctrl #(
    .DATA_W(W), .RECONF_CYCLES(RC), .RUN_MULT(RM), .BUF_DEPTH(DEPTH),
    .A_ADD(KADD), .B_MASK(KMSK)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
    .out_valid(out_valid), .out_ready(out_ready), .cfg(cfg), .busy(busy)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int vmode = 0;
  int rmode = 0;
  int acc = 0;
  logic [W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Input and back-pressure driver, away from the clock edge
  always @(posedge clk) begin
    #1;
    cyc++;
    in_data = W'(cyc * 37 + 13);
    case (vmode)
      1: in_valid = 1'b1;
      2: in_valid = cyc[0];
      3: in_valid = (cyc % 4 == 0);
      default: in_valid = 1'b0;
    endcase
    case (rmode)
      1: out_ready = (cyc % 3 != 0);
      2: out_ready = (cyc % 5 < 2);
      default: out_ready = 1'b1;
    endcase
  end

  // Monitor at the falling edge
  int prev_code = 0;
  int seg_len = 0;
  int last_run = 0;
  logic prev_hold = 1'b0;
  logic [W-1:0] prev_od = '0;

  always @(negedge clk) begin
    int code;
    if (!rst) begin
      code = !busy ? 0 : (cfg == 2'd1) ? 1 : (cfg == 2'd2) ? 2 : 3;
      if (code == prev_code) seg_len++;
      else begin
        case (prev_code)
          1: begin
            chk(seg_len == RUNL, "R2 producer window length", seg_len, RUNL);
            chk(code == 3, "R2 producer followed by stall", code, 3);
            last_run = 1;
          end
          3: begin
            chk(seg_len == RC, "R4 stall length", seg_len, RC);
            if (last_run == 1) chk(code == 2, "R2 stall then consumer", code, 2);
            else chk(code == 0 || code == 1, "R7 after second stall", code, 0);
          end
          2: begin
            chk(code == 3, "R2 consumer followed by stall", code, 3);
            last_run = 2;
          end
          default: chk(code == 1, "R2 idle to producer", code, 1);
        endcase
        seg_len = 1;
        prev_code = code;
      end
      if (code == 3)
        chk(!in_ready && !out_valid, "R4 stall quiet", {in_ready, out_valid}, 0);
      if (code != 1 && in_valid)
        chk(!in_ready, "R8 input refused outside producer", in_ready, 0);
      if (code == 3 && last_run == 2 && seg_len == 1)
        chk(exp_q.size() == 0, "R5 all bytes out before second stall", exp_q.size(), 0);
      if (prev_hold)
        chk(out_valid && out_data == prev_od, "R6 held output", out_data, prev_od);
      if (in_valid && in_ready) begin
        exp_q.push_back((in_data + KADD) ^ KMSK);
        acc++;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected output", out_data, 0);
        else chk(out_data == exp_q[0], "R5 output value and order", out_data, exp_q[0]);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
      end
      prev_hold = out_valid && !out_ready;
      prev_od = out_data;
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_pass(input int vm, input int rm, input int exp_acc, input string tag);
    vmode = vm;
    rmode = rm;
    acc = 0;
    @(posedge clk); #2;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    wait_idle();
    chk(acc == exp_acc, tag, acc, exp_acc);
    chk(exp_q.size() == 0, "R5 buffer fully delivered", exp_q.size(), 0);
    chk(cfg == 2'd0 && !in_ready && !out_valid, "R7 idle after pass",
        {cfg, in_ready, out_valid}, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(!busy && cfg == 2'd0 && !in_ready && !out_valid, "R1 reset state",
        {busy, cfg, in_ready, out_valid}, 0);
    vmode = 1;
    repeat (5) @(negedge clk);
    chk(!busy && !in_ready, "R1 R8 idle ignores input", {busy, in_ready}, 0);

    run_pass(1, 0, DEPTH, "R3 saturated accept count");
    run_pass(2, 1, RUNL / 2, "R3 every-other accept count");
    run_pass(3, 2, RUNL / 4, "R3 sparse accept count");
    run_pass(0, 0, 0, "R3 empty pass accept count");

    // start held: a second pass follows with no idle cycle
    vmode = 1;
    rmode = 1;
    acc = 0;
    @(posedge clk); #2;
    start = 1'b1;
    @(negedge clk);
    while (cfg != 2'd2) @(negedge clk);
    while (cfg != 2'd1 && busy) @(negedge clk);
    chk(cfg == 2'd1 && busy, "R7 held start restarts producer", cfg, 1);
    start = 1'b0;
    wait_idle();
    chk(acc == 2 * DEPTH, "R3 two saturated passes", acc, 2 * DEPTH);
    chk(exp_q.size() == 0, "R5 back-to-back delivered", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule